// File: doc/BRIEF.md
# Multi-Counter Event Monitoring Unit

This unit watches a shared cache slice through a 256-line event vector. It counts the cycles in which chosen events occur, in eight independent counters. Software configures it over a simple register bus. Each counter picks its event line with an 8-bit code. Counting is gated by one global run bit and by a per-counter enable bit. When a counter wraps past its top value, a pending bit is latched, and unless that bit is masked it raises the single interrupt line.

Control and status registers are 32 bits wide and sit in the low half of the 64-bit data bus. The counters are read and written as whole 64-bit words. The counter width is a build parameter. In a 48-bit build the upper sixteen bits of every counter read as zero and drop whatever is written to them. A read returns its data one cycle after the request, together with a valid strobe.

Top module: `evmon_unit`

## Requirements
- R1: After reset the following hold: all counters are zero, the per-counter enables are zero, the run bit is zero, all pending bits are zero, all mask bits are one, every event code is 0xFF, and `irq` is low.
- R2: A counter increments by one on each clock edge at which three conditions are all true: the run bit (bit 16 of 0x0408) is set, its enable bit i of 0x1C00 is set, and the event line indexed by its code is high.
- R3: A counter whose code is 0xFF never advances, even when event line 255 is high.
- R4: Event codes are packed four per word. Codes for counters 0 to 3 live at 0x1D00, codes for counters 4 to 7 live at 0x1D04, and counter i uses bits 8*(i mod 4)+7 down to 8*(i mod 4). The words read back as written.
- R5: With the run bit clear, no counter changes except by a bus write.
- R6: Counter i is a 64-bit register at 0x1E00 + 8*i. A write to it is visible on the next read. A write takes priority over an increment in the same cycle.
- R7: In a build with counter width below 64, the counter bits above the width read as zero and ignore writes.
- R8: A counter that wraps from all ones to zero at its width sets its bit i in the pending register at 0x0808.
- R9: Writing 1 to bit i of 0x080C clears pending bit i, and writing 0 leaves it unchanged. An overflow in the same cycle as a clear leaves the bit set. Reads of 0x080C return zero.
- R10: Mask bit i of 0x0800 set to 1 blocks counter i's interrupt, and 0 lets it through. `irq` is registered: it equals the OR of (pending AND NOT mask) as it stood one cycle earlier.
- R11: The register at 0x1CF0 reads the `IDENT` parameter and ignores writes.
- R12: `reg_rvalid` pulses in the cycle after `reg_rd` and carries the read data at that point. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 16 | Byte address |
| reg_wdata | input | 64 | Write data (control registers use bits 31:0) |
| reg_rdata | output | 64 | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| event_in | input | 256 | Event lines, indexed by event code |
| irq | output | 1 | Registered overflow interrupt |

## Verification
Each result has a fixed delay. A register write or an event present before edge T changes the counters and pending bits at T. Read data for a request at T appears just after T. `irq` follows the pending and mask state one edge later, so it settles two edges after the write or wrap that causes it. The bench drives every input at the falling edge. It samples one nanosecond after the rising edge at which the result is due. Before each interrupt check it waits out the extra edge. Event pulses are held for exactly one rising edge, so the bench model advances once per pulse.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int unsigned REG_AW = 16;

  // register map (byte addresses)
  localparam logic [REG_AW-1:0] A_RUNCTL  = 16'h0408;
  localparam logic [REG_AW-1:0] A_IRQMASK = 16'h0800;
  localparam logic [REG_AW-1:0] A_IRQPEND = 16'h0808;
  localparam logic [REG_AW-1:0] A_IRQACK  = 16'h080C;
  localparam logic [REG_AW-1:0] A_CNTEN   = 16'h1C00;
  localparam logic [REG_AW-1:0] A_IDENT   = 16'h1CF0;
  localparam logic [REG_AW-1:0] A_EVSEL   = 16'h1D00;
  localparam logic [REG_AW-1:0] A_CNTBASE = 16'h1E00;

  localparam int unsigned RUN_BIT = 16;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BUS_W   = 64;
endpackage

// File: rtl/evmon_regs.sv
module evmon_regs
  import evmon_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned CODE_W  = 8,
  localparam int unsigned PER_WORD = WORD_W / CODE_W,
  localparam int unsigned NSEL     = (NUM_CNT + PER_WORD - 1) / PER_WORD
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr,
  input  logic [REG_AW-1:0]             addr,
  input  logic [WORD_W-1:0]             wdata,
  output logic                          run,
  output logic [NUM_CNT-1:0]            cnt_en,
  output logic [NUM_CNT-1:0]            irq_mask,
  output logic [NUM_CNT-1:0]            ack_vec,
  output logic [NSEL-1:0][WORD_W-1:0]   sel_words,
  output logic [NUM_CNT-1:0][CODE_W-1:0] codes
);
  logic                        run_q;
  logic [NUM_CNT-1:0]          en_q;
  logic [NUM_CNT-1:0]          mask_q;
  logic [NSEL-1:0][WORD_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      en_q   <= '0;
      mask_q <= '1;
      sel_q  <= '1;
    end else if (wr) begin
      if (addr == A_RUNCTL)  run_q  <= wdata[RUN_BIT];
      if (addr == A_CNTEN)   en_q   <= wdata[NUM_CNT-1:0];
      if (addr == A_IRQMASK) mask_q <= wdata[NUM_CNT-1:0];
      for (int k = 0; k < NSEL; k++) begin
        if (addr == A_EVSEL + REG_AW'(4 * k)) sel_q[k] <= wdata;
      end
    end
  end

  // clear pulse: only bits written as one, only for the acknowledge address
  assign ack_vec = (wr && addr == A_IRQACK) ? wdata[NUM_CNT-1:0] : '0;

  generate
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_code
      assign codes[i] = sel_q[i / PER_WORD][(i % PER_WORD) * CODE_W +: CODE_W];
    end
  endgenerate

  assign run       = run_q;
  assign cnt_en    = en_q;
  assign irq_mask  = mask_q;
  assign sel_words = sel_q;
endmodule

// File: rtl/evmon_counter.sv
module evmon_counter #(
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned CODE_W = 8,
  localparam int unsigned EVT_W = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic [EVT_W-1:0]  events,
  input  logic              ld,
  input  logic [CNT_W-1:0]  ld_val,
  output logic [CNT_W-1:0]  count,
  output logic              wrap
);
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  // all-ones code selects nothing
  assign hit  = run && en && (code != '1) && events[code];
  assign wrap = hit && !ld && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (ld)  cnt_q <= ld_val;
    else if (hit) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
endmodule

// File: rtl/evmon_irq.sv
module evmon_irq #(
  parameter int unsigned NUM_CNT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] wrap_vec,
  input  logic [NUM_CNT-1:0] ack_vec,
  input  logic [NUM_CNT-1:0] mask,
  output logic [NUM_CNT-1:0] pend,
  output logic               irq
);
  logic [NUM_CNT-1:0] pend_q;
  logic               irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~ack_vec) | wrap_vec;  // overflow beats clear
      irq_q  <= |(pend_q & ~mask);
    end
  end

  assign pend = pend_q;
  assign irq  = irq_q;
endmodule

// File: rtl/evmon_unit.sv
module evmon_unit
  import evmon_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned CNT_W   = 48,
  parameter int unsigned CODE_W  = 8,
  parameter logic [31:0] IDENT   = 32'h0002_0001,
  localparam int unsigned EVT_W    = 1 << CODE_W,
  localparam int unsigned PER_WORD = WORD_W / CODE_W,
  localparam int unsigned NSEL     = (NUM_CNT + PER_WORD - 1) / PER_WORD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [15:0]       reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              reg_rvalid,
  input  logic [EVT_W-1:0]  event_in,
  output logic              irq
);
  logic                          run;
  logic [NUM_CNT-1:0]            cnt_en;
  logic [NUM_CNT-1:0]            mask;
  logic [NUM_CNT-1:0]            ack_vec;
  logic [NSEL-1:0][WORD_W-1:0]   sel_words;
  logic [NUM_CNT-1:0][CODE_W-1:0] codes;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_CNT-1:0]            wrap_vec;
  logic [NUM_CNT-1:0]            ld_vec;
  logic [NUM_CNT-1:0]            pend;
  logic [BUS_W-1:0]              rd_next;
  logic [BUS_W-1:0]              rdata_q;
  logic                          rvalid_q;
  logic                          unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata;

  evmon_regs #(.NUM_CNT(NUM_CNT), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata[WORD_W-1:0]), .run(run), .cnt_en(cnt_en),
    .irq_mask(mask), .ack_vec(ack_vec), .sel_words(sel_words), .codes(codes)
  );

  generate
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      assign ld_vec[i] = reg_wr && (reg_addr == A_CNTBASE + REG_AW'(8 * i));
      evmon_counter #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_cnt (
        .clk(clk), .rst(rst), .run(run), .en(cnt_en[i]), .code(codes[i]),
        .events(event_in), .ld(ld_vec[i]), .ld_val(reg_wdata[CNT_W-1:0]),
        .count(cnt_q[i]), .wrap(wrap_vec[i])
      );
    end
  endgenerate

  evmon_irq #(.NUM_CNT(NUM_CNT)) u_irq (
    .clk(clk), .rst(rst), .wrap_vec(wrap_vec), .ack_vec(ack_vec),
    .mask(mask), .pend(pend), .irq(irq)
  );

  always_comb begin
    rd_next = '0;
    if (reg_addr == A_RUNCTL)  rd_next[RUN_BIT]       = run;
    if (reg_addr == A_CNTEN)   rd_next[NUM_CNT-1:0]   = cnt_en;
    if (reg_addr == A_IRQMASK) rd_next[NUM_CNT-1:0]   = mask;
    if (reg_addr == A_IRQPEND) rd_next[NUM_CNT-1:0]   = pend;
    if (reg_addr == A_IDENT)   rd_next[WORD_W-1:0]    = IDENT;
    for (int k = 0; k < NSEL; k++) begin
      if (reg_addr == A_EVSEL + REG_AW'(4 * k)) rd_next[WORD_W-1:0] = sel_words[k];
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr == A_CNTBASE + REG_AW'(8 * i)) rd_next[CNT_W-1:0] = cnt_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_rd;
      if (reg_rd) rdata_q <= rd_next;
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;
endmodule

// File: rtl/evmon_checker.sv
module evmon_checker #(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned CNT_W   = 48
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          reg_wr,
  input logic                          reg_rd,
  input logic [15:0]                   reg_addr,
  input logic                          reg_rvalid,
  input logic                          irq,
  input logic                          run,
  input logic [NUM_CNT-1:0]            pend,
  input logic [NUM_CNT-1:0]            mask,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnts
);
  logic cnt_wr;
  assign cnt_wr = reg_wr && reg_addr >= 16'h1E00 && reg_addr < 16'h1E00 + 16'(8 * NUM_CNT);

  assert_reset_clean_R1: assert property (@(posedge clk)
    $past(rst) && !rst |-> (pend == '0 && !irq && !run));

  assert_frozen_counts_R5: assert property (@(posedge clk) disable iff (rst)
    !run && !cnt_wr |=> $stable(cnts));

  assert_pend_needs_run_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(run) |-> (pend & ~$past(pend)) == '0);

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq == $past(|(pend & ~mask)));

  assert_rvalid_timing_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> reg_rvalid == $past(reg_rd));
endmodule

bind evmon_unit evmon_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_evmon_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rvalid(reg_rvalid), .irq(irq), .run(run), .pend(pend), .mask(mask),
  .cnts(cnt_q)
);

// File: tb/test_evmon_unit.sv
`timescale 1ns/1ps
module test_evmon_unit;
  localparam int NUM_CNT = 8;
  localparam int CNT_W   = 48;
  localparam logic [31:0] IDENT = 32'h0002_0001;
  localparam logic [63:0] WMASK = (64'd1 << CNT_W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0]  reg_addr = '0;
  logic [63:0]  reg_wdata = '0;
  logic [63:0]  reg_rdata;
  logic         reg_rvalid;
  logic [255:0] event_in = '0;
  logic         irq;

  int n_chk = 0, n_bad = 0;
  logic [63:0]        m_cnt [NUM_CNT];
  logic [7:0]         m_code [NUM_CNT];
  logic [NUM_CNT-1:0] m_en;
  logic               m_run;

  evmon_unit #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .IDENT(IDENT)) i_evmon_unit (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .event_in(event_in), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [63:0] d, output logic v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1; d = reg_rdata; v = reg_rvalid; reg_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [63:0] exp, input string what);
    logic [63:0] d; logic v;
    rd(a, d, v);
    check(req, d, exp, what);
  endtask

  function automatic logic [255:0] rand_ev();
    logic [255:0] e;
    for (int k = 0; k < 8; k++) e[k*32 +: 32] = $urandom;
    return e;
  endfunction

  // one event pattern held across exactly one rising edge; model advances
  task automatic tick(input logic [255:0] ev);
    @(negedge clk); event_in = ev;
    for (int i = 0; i < NUM_CNT; i++)
      if (m_run && m_en[i] && m_code[i] != 8'hFF && ev[m_code[i]])
        m_cnt[i] = (m_cnt[i] + 64'd1) & WMASK;
    @(posedge clk); #1; event_in = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [63:0] d; logic v;
    void'($urandom(32'd2024));
    for (int i = 0; i < NUM_CNT; i++) begin m_cnt[i] = '0; m_code[i] = 8'hFF; end
    m_en = '0; m_run = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check("R1", {63'd0, irq}, 64'd0, "irq after reset");
    rd_chk("R1", 16'h0408, 64'd0, "run control");
    rd_chk("R1", 16'h1C00, 64'd0, "enables");
    rd_chk("R1", 16'h0800, 64'hFF, "mask");
    rd_chk("R1", 16'h0808, 64'd0, "pending");
    rd_chk("R1", 16'h1D04, 64'hFFFF_FFFF, "codes 4-7");
    rd_chk("R1", 16'h1E18, 64'd0, "counter 3");

    // R11 identifier, R12 read timing and unmapped reads
    rd_chk("R11", 16'h1CF0, {32'd0, IDENT}, "ident");
    wr(16'h1CF0, 64'h1234_5678);
    rd_chk("R11", 16'h1CF0, {32'd0, IDENT}, "ident after write");
    rd(16'h0404, d, v);
    check("R12", d, 64'd0, "unmapped read");
    check("R12", {63'd0, v}, 64'd1, "rvalid with data");
    @(posedge clk); #1;
    check("R12", {63'd0, reg_rvalid}, 64'd0, "rvalid drops");
    rd_chk("R9", 16'h080C, 64'd0, "clear register reads zero");

    // R2 R3 R4 random counting
    for (int i = 0; i < NUM_CNT; i++) m_code[i] = 8'($urandom_range(0, 254));
    m_code[3] = 8'hFF;
    m_en = 8'($urandom) | 8'h08;
    wr(16'h1D00, {32'd0, m_code[3], m_code[2], m_code[1], m_code[0]});
    wr(16'h1D04, {32'd0, m_code[7], m_code[6], m_code[5], m_code[4]});
    rd_chk("R4", 16'h1D04, {32'd0, m_code[7], m_code[6], m_code[5], m_code[4]}, "codes 4-7 readback");
    wr(16'h1C00, {56'd0, m_en});
    wr(16'h0408, 64'd1 << 16); m_run = 1'b1;
    for (int t = 0; t < 300; t++) begin
      logic [255:0] e;
      e = rand_ev();
      if (t % 3 == 0) e[255] = 1'b1;
      tick(e);
    end
    wr(16'h0408, 64'd0); m_run = 1'b0;
    for (int i = 0; i < NUM_CNT; i++)
      rd_chk(i == 3 ? "R3" : "R2 R4", 16'h1E00 + 16'(8 * i), m_cnt[i], $sformatf("counter %0d", i));

    // R5 frozen while run clear
    for (int t = 0; t < 40; t++) tick(rand_ev());
    for (int i = 0; i < NUM_CNT; i++)
      rd_chk("R5", 16'h1E00 + 16'(8 * i), m_cnt[i], $sformatf("frozen counter %0d", i));

    // R6 R7 counter access
    wr(16'h1E38, 64'h0000_0000_DEAD_BEEF);
    rd_chk("R6", 16'h1E38, 64'h0000_0000_DEAD_BEEF, "counter 7 write");
    wr(16'h1E28, 64'hFFFF_1234_5678_9ABC);
    rd_chk("R7", 16'h1E28, 64'h0000_1234_5678_9ABC, "upper bits dropped");

    // R8 R9 R10 overflow path on counter 2, code 0x10
    for (int i = 0; i < NUM_CNT; i++) m_code[i] = 8'hFF;
    m_code[2] = 8'h10; m_en = 8'h04;
    wr(16'h1D00, 64'hFF10_FFFF);
    wr(16'h1D04, 64'hFFFF_FFFF);
    wr(16'h1C00, 64'h04);
    wr(16'h1E10, WMASK - 64'd1);
    wr(16'h0408, 64'd1 << 16); m_run = 1'b1;
    tick(256'd1 << 8'h10);
    rd_chk("R8", 16'h0808, 64'd0, "no pending before wrap");
    tick(256'd1 << 8'h10);
    rd_chk("R8", 16'h1E10, 64'd0, "counter wrapped to zero");
    rd_chk("R8", 16'h0808, 64'h04, "pending after wrap");
    check("R10", {63'd0, irq}, 64'd0, "masked irq");
    wr(16'h0800, 64'hFB);
    @(posedge clk); #1;
    check("R10", {63'd0, irq}, 64'd1, "unmasked irq");
    wr(16'h080C, 64'h00);
    rd_chk("R9", 16'h0808, 64'h04, "zero write keeps pending");
    wr(16'h080C, 64'h04);
    rd_chk("R9", 16'h0808, 64'd0, "one write clears pending");
    check("R10", {63'd0, irq}, 64'd0, "irq after clear");

    // R9 overflow wins over a same-cycle clear
    wr(16'h1E10, WMASK);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 16'h080C; reg_wdata = 64'h04;
    event_in = 256'd1 << 8'h10;
    @(posedge clk); #1; event_in = '0;
    @(negedge clk); reg_wr = 1'b0;
    rd_chk("R9", 16'h0808, 64'h04, "overflow beats clear");
    wr(16'h080C, 64'h04);

    // R6 write beats a same-cycle increment
    @(negedge clk); reg_wr = 1'b1; reg_addr = 16'h1E10; reg_wdata = 64'd100;
    event_in = 256'd1 << 8'h10;
    @(posedge clk); #1; event_in = '0;
    @(negedge clk); reg_wr = 1'b0;
    wr(16'h0408, 64'd0);
    rd_chk("R6", 16'h1E10, 64'd100, "write priority");

    finish_run();
  end
endmodule